// File: doc/BRIEF.md
# Oversampling Serial Receiver with Push-Out

This block takes asynchronous serial frames from one input line and turns each into a byte that is offered to a downstream FIFO. A free-running divider produces a tick at sixteen times the chosen bit rate. The tick runs only while the enable pin is high. The rate comes from a two-bit select. The divider values are computed at elaboration from the system clock frequency parameter, rounded to the nearest integer.

The frame engine synchronizes the line and confirms a start bit half a bit period after it is first seen. It then takes each data bit at the middle of its bit period, least significant bit first. An optional parity bit follows the data, then two stop bits. A completed byte sets an internal ready flag. A four-step handoff sequencer sees the flag, waits one cycle, then offers the byte on a valid/ready output. The accepting cycle pulses an active-low read strobe that clears the flag. The sequencer then waits for the flag to fall.

Back-pressure rules: `out_valid` stays high and the byte stays on `out_data` until `out_ready` is high in a cycle. There is one exception. If a further frame completes while the byte is still waiting, the newer byte replaces it and `out_ovr_err` is raised. The three error flags travel with the byte they describe.

Top module: `uart_rx_pushout`

## Requirements
- R1: `rate_sel` picks the bit rate: 2'b00 gives 9600, 2'b01 gives 19200, 2'b10 gives 57600 and 2'b11 gives 115200 baud. The tick period is round(CLK_HZ / (16 × baud)) system cycles, and one bit lasts 16 ticks.
- R2: While `rx_en` is low, no ticks occur, the frame engine sits idle and no byte is produced from any line activity.
- R3: A low level on the line is taken as a start bit only if it is still low 8 ticks after it was first seen. A shorter low pulse produces no byte.
- R4: A frame is a low start bit, then 8 data bits sent least significant bit first, then (if parity is enabled) a parity bit, then two stop bits. Each bit is sampled at its centre tick, and the assembled byte appears on `out_data`.
- R5: With `par_en` high, the bit after the data is a parity bit. `par_odd` low selects even parity and high selects odd parity. A mismatch sets `out_par_err` for that byte. With `par_en` low, `out_par_err` is 0.
- R6: `out_frm_err` is 1 for a byte when either stop-bit sample was low, and 0 otherwise.
- R7: Each received byte is transferred exactly once. `out_valid` rises one cycle after the sequencer sees the internal ready flag, and it drops in the cycle after the transfer.
- R8: While `out_ready` is low, `out_valid` and `out_data` hold. If another frame completes in that time, its byte replaces the waiting one with `out_ovr_err` = 1. Otherwise `out_ovr_err` is 0.
- R9: After reset, `out_valid`, `out_data` and all three error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable; low stops the tick and idles the receiver |
| rate_sel | input | 2 | Bit-rate select (R1 encoding) |
| par_en | input | 1 | Parity bit present after the data |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| out_valid | output | 1 | A received byte is offered |
| out_ready | input | 1 | Downstream FIFO can accept (not full) |
| out_data | output | 8 | Received byte |
| out_par_err | output | 1 | Parity mismatch for this byte |
| out_frm_err | output | 1 | A stop bit of this byte was low |
| out_ovr_err | output | 1 | This byte overwrote one that was never accepted |

## Verification
A byte becomes available about half a bit period into the second stop bit. That point is two synchronizer cycles plus up to one tick period after the ideal centre. The byte is offered two cycles after the ready flag is set, and accepted in the first cycle with `out_ready` high. The arrival cycle depends on the tick phase, so a scoreboard monitor compares each accepted byte and its flags with the queue, sampling mid-cycle. After every frame the bench waits a full idle bit, which is far past the latest arrival, and then checks that the queue is empty. The hold, overwrite and no-output cases are checked at fixed points between frames.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
package uart_rx_pkg;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_START,
    FR_DATA,
    FR_PAR,
    FR_STOP
  } fr_state_t;

  typedef enum logic [1:0] {
    HO_IDLE,
    HO_SEEN,
    HO_OFFER,
    HO_DRAIN
  } ho_state_t;

  // Tick period in system cycles for a 16x oversample, nearest integer.
  function automatic int unsigned tick_div(input int unsigned clk_hz,
                                           input int unsigned baud);
    return (clk_hz + 8 * baud) / (16 * baud);
  endfunction

endpackage

// File: rtl/uart_rx_baudgen.sv
`timescale 1ns/1ps
module uart_rx_baudgen #(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned BAUD_R0 = 9600,
  parameter int unsigned BAUD_R1 = 19200,
  parameter int unsigned BAUD_R2 = 57600,
  parameter int unsigned BAUD_R3 = 115200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] rate_sel,
  output logic       tick
);
  localparam int unsigned DIV0 = uart_rx_pkg::tick_div(CLK_HZ, BAUD_R0);
  localparam int unsigned DIV1 = uart_rx_pkg::tick_div(CLK_HZ, BAUD_R1);
  localparam int unsigned DIV2 = uart_rx_pkg::tick_div(CLK_HZ, BAUD_R2);
  localparam int unsigned DIV3 = uart_rx_pkg::tick_div(CLK_HZ, BAUD_R3);
  // Rate 0 is the slowest and sets the counter width.
  localparam int unsigned CW   = $clog2(DIV0) + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  always_comb begin
    case (rate_sel)
      2'b00:   lim = CW'(DIV0 - 1);
      2'b01:   lim = CW'(DIV1 - 1);
      2'b10:   lim = CW'(DIV2 - 1);
      default: lim = CW'(DIV3 - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (!en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= lim) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // R2: a cleared enable silences the tick from the next cycle
  p_tick_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !tick);
  // R1: every divider value is at least two, so ticks never come back to back
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/uart_rx_sync.sv
`timescale 1ns/1ps
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/uart_rx_frame.sv
`timescale 1ns/1ps
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned OSR       = 16,
  parameter int unsigned STOP_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              line,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rd_n,
  output logic              rdy,
  output logic [DATA_W-1:0] data,
  output logic              par_err,
  output logic              frm_err,
  output logic              ovr_err
);
  localparam int unsigned CNT_W  = $clog2(OSR);
  localparam int unsigned IDX_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int unsigned SIDX_W = (STOP_BITS > 1) ? $clog2(STOP_BITS) : 1;
  localparam logic [CNT_W-1:0]  MID   = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0]  LAST  = CNT_W'(OSR - 1);
  localparam logic [IDX_W-1:0]  DLAST = IDX_W'(DATA_W - 1);
  localparam logic [SIDX_W-1:0] SLAST = SIDX_W'(STOP_BITS - 1);

  fr_state_t         st;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [SIDX_W-1:0] sidx;
  logic [DATA_W-1:0] sh;
  logic              perr_acc;
  logic              ferr_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= FR_IDLE;
      cnt      <= '0;
      idx      <= '0;
      sidx     <= '0;
      sh       <= '0;
      perr_acc <= 1'b0;
      ferr_acc <= 1'b0;
      rdy      <= 1'b0;
      data     <= '0;
      par_err  <= 1'b0;
      frm_err  <= 1'b0;
      ovr_err  <= 1'b0;
    end else begin
      // The read strobe clears the flag; a completion below overrides it.
      if (!rd_n) rdy <= 1'b0;

      if (!en) begin
        st  <= FR_IDLE;
        cnt <= '0;
      end else if (tick) begin
        case (st)
          FR_IDLE: begin
            if (!line) begin
              st  <= FR_START;
              cnt <= '0;
            end
          end
          FR_START: begin
            if (cnt == MID) begin
              cnt <= '0;
              idx <= '0;
              st  <= line ? FR_IDLE : FR_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          FR_DATA: begin
            if (cnt == LAST) begin
              cnt <= '0;
              sh  <= {line, sh[DATA_W-1:1]};
              if (idx == DLAST) begin
                sidx     <= '0;
                ferr_acc <= 1'b0;
                perr_acc <= 1'b0;
                st       <= par_en ? FR_PAR : FR_STOP;
              end else begin
                idx <= idx + 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          FR_PAR: begin
            if (cnt == LAST) begin
              cnt      <= '0;
              perr_acc <= (^sh) ^ line ^ par_odd;
              st       <= FR_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          FR_STOP: begin
            if (cnt == LAST) begin
              cnt <= '0;
              if (sidx == SLAST) begin
                data    <= sh;
                par_err <= perr_acc;
                frm_err <= ferr_acc | ~line;
                ovr_err <= rdy & rd_n;
                rdy     <= 1'b1;
                st      <= FR_IDLE;
              end else begin
                sidx     <= sidx + 1'b1;
                ferr_acc <= ferr_acc | ~line;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= FR_IDLE;
        endcase
      end
    end
  end

  // R2: disabling returns the engine to idle on the next edge
  p_idle_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (st == FR_IDLE));
  // R4: a byte is only ever announced out of the stop-bit phase
  p_ready_from_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> ($past(st) == FR_STOP));
  // R7: the read strobe clears ready unless a byte completes at that edge
  p_ready_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && st != FR_STOP) |=> !rdy);

endmodule

// File: rtl/uart_rx_handoff.sv
`timescale 1ns/1ps
module uart_rx_handoff
  import uart_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rdy,
  input  logic out_ready,
  output logic out_valid,
  output logic rd_n
);
  ho_state_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= HO_IDLE;
    end else begin
      case (st)
        HO_IDLE:  if (rdy) st <= HO_SEEN;
        HO_SEEN:  st <= HO_OFFER;
        HO_OFFER: if (out_ready) st <= HO_DRAIN;
        // A byte that completes on the strobe edge keeps ready high.
        HO_DRAIN: st <= rdy ? HO_SEEN : HO_IDLE;
        default:  st <= HO_IDLE;
      endcase
    end
  end

  assign out_valid = (st == HO_OFFER);
  assign rd_n      = !((st == HO_OFFER) && out_ready);

  // R8: an offer that is not taken stays up
  p_hold_offer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);
  // R7: one transfer per byte, the offer drops right after it
  p_single_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_valid);
  // R7: nothing is offered unless the receiver holds a byte
  p_offer_has_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> rdy);

endmodule

// File: rtl/uart_rx_pushout.sv
`timescale 1ns/1ps
module uart_rx_pushout #(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned BAUD_R0     = 9600,
  parameter int unsigned BAUD_R1     = 19200,
  parameter int unsigned BAUD_R2     = 57600,
  parameter int unsigned BAUD_R3     = 115200,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned OSR         = 16,
  parameter int unsigned STOP_BITS   = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic [1:0]        rate_sel,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rx_line,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_par_err,
  output logic              out_frm_err,
  output logic              out_ovr_err
);
  logic tick;
  logic line_s;
  logic rdy;
  logic rd_n;

  uart_rx_baudgen #(
    .CLK_HZ (CLK_HZ),
    .BAUD_R0(BAUD_R0),
    .BAUD_R1(BAUD_R1),
    .BAUD_R2(BAUD_R2),
    .BAUD_R3(BAUD_R3)
  ) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (rx_en),
    .rate_sel(rate_sel),
    .tick    (tick)
  );

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (rx_line),
    .q    (line_s)
  );

  uart_rx_frame #(
    .DATA_W   (DATA_W),
    .OSR      (OSR),
    .STOP_BITS(STOP_BITS)
  ) u_frame (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (rx_en),
    .tick   (tick),
    .line   (line_s),
    .par_en (par_en),
    .par_odd(par_odd),
    .rd_n   (rd_n),
    .rdy    (rdy),
    .data   (out_data),
    .par_err(out_par_err),
    .frm_err(out_frm_err),
    .ovr_err(out_ovr_err)
  );

  uart_rx_handoff u_handoff (
    .clk      (clk),
    .rst_n    (rst_n),
    .rdy      (rdy),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .rd_n     (rd_n)
  );

endmodule

// File: tb/uart_rx_pushout_bench.sv
`timescale 1ns/1ps
module uart_rx_pushout_bench;

  typedef struct packed {
    logic [7:0] data;
    logic       pe;
    logic       fe;
    logic       oe;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0;
  logic [1:0] rate_sel = 2'b11;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       rx_line = 1'b1;
  logic       out_ready = 1'b1;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_par_err, out_frm_err, out_ovr_err;

  int unsigned checks = 0;
  int unsigned errors = 0;
  item_t       exp_q[$];
  bit          done = 1'b0;

  always #10 clk = ~clk;

  uart_rx_pushout u_uart_rx_pushout (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .rate_sel   (rate_sel),
    .par_en     (par_en),
    .par_odd    (par_odd),
    .rx_line    (rx_line),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_par_err(out_par_err),
    .out_frm_err(out_frm_err),
    .out_ovr_err(out_ovr_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // R1: system cycles per bit = 16 * round(50 MHz / (16 * baud))
  function automatic int unsigned bit_cycles(input logic [1:0] r);
    int unsigned b;
    case (r)
      2'b00:   b = 9600;
      2'b01:   b = 19200;
      2'b10:   b = 57600;
      default: b = 115200;
    endcase
    return 16 * ((50_000_000 + 8 * b) / (16 * b));
  endfunction

  task automatic hold_line(input logic v, input int unsigned n);
    rx_line = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input bit with_par,
                            input bit pbit, input bit s1, input bit s2);
    int unsigned bc;
    bc = bit_cycles(rate_sel);
    hold_line(1'b0, bc);
    for (int i = 0; i < 8; i++) hold_line(b[i], bc);
    if (with_par) hold_line(pbit, bc);
    hold_line(s1, bc);
    hold_line(s2, bc);
    hold_line(1'b1, bc);
  endtask

  task automatic expect_item(input logic [7:0] d, input bit pe, input bit fe,
                             input bit oe);
    exp_q.push_back({d, pe, fe, oe});
  endtask

  task automatic check_drained(input string req);
    check(exp_q.size() == 0, req, "queue not drained", exp_q.size(), 0);
  endtask

  // Monitor: samples mid-cycle, compares each accepted byte.
  always begin
    @(negedge clk);
    #5;
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7", "unexpected byte",
              {20'h0, out_data, out_par_err, out_frm_err, out_ovr_err}, 0);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        check({out_data, out_par_err, out_frm_err, out_ovr_err} == e,
              "R4", "byte+flags {data,pe,fe,oe}",
              {20'h0, out_data, out_par_err, out_frm_err, out_ovr_err},
              {20'h0, e});
      end
    end
  end

  initial begin
    repeat (190_000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R9: reset state
    check(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
    check({out_data, out_par_err, out_frm_err, out_ovr_err} == 11'h0, "R9",
          "data/flags after reset",
          {21'h0, out_data, out_par_err, out_frm_err, out_ovr_err}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rx_en = 1'b1;
    repeat (bit_cycles(rate_sel)) @(negedge clk);

    // R4, R1: plain frames at 115200
    expect_item(8'hA5, 0, 0, 0); send_frame(8'hA5, 0, 0, 1, 1);
    expect_item(8'h3C, 0, 0, 0); send_frame(8'h3C, 0, 0, 1, 1);
    expect_item(8'h00, 0, 0, 0); send_frame(8'h00, 0, 0, 1, 1);
    expect_item(8'hFF, 0, 0, 0); send_frame(8'hFF, 0, 0, 1, 1);
    check_drained("R4");

    // R5: even parity good and bad, odd parity good and bad
    par_en = 1'b1; par_odd = 1'b0;
    expect_item(8'h5A, 0, 0, 0); send_frame(8'h5A, 1, ^8'h5A, 1, 1);
    expect_item(8'h81, 1, 0, 0); send_frame(8'h81, 1, ~(^8'h81), 1, 1);
    par_odd = 1'b1;
    expect_item(8'h07, 0, 0, 0); send_frame(8'h07, 1, ~(^8'h07), 1, 1);
    expect_item(8'h10, 1, 0, 0); send_frame(8'h10, 1, ^8'h10, 1, 1);
    check_drained("R5");
    par_en = 1'b0; par_odd = 1'b0;

    // R6: first stop low, then second stop low
    expect_item(8'h66, 0, 1, 0); send_frame(8'h66, 0, 0, 0, 1);
    expect_item(8'h99, 0, 1, 0); send_frame(8'h99, 0, 0, 1, 0);
    hold_line(1'b1, bit_cycles(rate_sel));
    check_drained("R6");

    // R3: a low pulse of 4 ticks is no start bit
    hold_line(1'b0, bit_cycles(rate_sel) / 4);
    hold_line(1'b1, 2 * bit_cycles(rate_sel));
    check(out_valid == 1'b0, "R3", "valid after glitch", out_valid, 0);
    check_drained("R3");
    expect_item(8'h5C, 0, 0, 0); send_frame(8'h5C, 0, 0, 1, 1);
    check_drained("R3");

    // R2: disabled receiver ignores a full frame
    rx_en = 1'b0;
    send_frame(8'h42, 0, 0, 1, 1);
    check(out_valid == 1'b0, "R2", "valid while disabled", out_valid, 0);
    check(out_data == 8'h5C, "R2", "data while disabled", out_data, 8'h5C);
    rx_en = 1'b1;
    hold_line(1'b1, bit_cycles(rate_sel));
    expect_item(8'h24, 0, 0, 0); send_frame(8'h24, 0, 0, 1, 1);
    check_drained("R2");

    // R8: back-pressure holds the byte, a second frame overwrites it
    out_ready = 1'b0;
    send_frame(8'h11, 0, 0, 1, 1);
    check(out_valid == 1'b1, "R8", "valid held", out_valid, 1);
    check(out_data == 8'h11, "R8", "data held", out_data, 8'h11);
    check(out_ovr_err == 1'b0, "R8", "no overrun yet", out_ovr_err, 0);
    expect_item(8'h22, 0, 0, 1);
    send_frame(8'h22, 0, 0, 1, 1);
    check(out_valid == 1'b1, "R8", "valid after overwrite", out_valid, 1);
    out_ready = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R7", "valid drops after transfer", out_valid, 0);
    check_drained("R8");
    expect_item(8'h33, 0, 0, 0); send_frame(8'h33, 0, 0, 1, 1);
    check_drained("R8");

    // R1: other rates
    rate_sel = 2'b10;
    hold_line(1'b1, bit_cycles(rate_sel));
    expect_item(8'hC3, 0, 0, 0); send_frame(8'hC3, 0, 0, 1, 1);
    check_drained("R1");
    rate_sel = 2'b01;
    hold_line(1'b1, bit_cycles(rate_sel));
    expect_item(8'h5E, 0, 0, 0); send_frame(8'h5E, 0, 0, 1, 1);
    check_drained("R1");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule